// File: doc/BRIEF.md
# PLL Power-Up Sequencer with Lock Timeout

This block sequences a fixed-multiplier PLL on and off. The PLL multiplies its reference by an integer factor, and that factor is the 3-bit register code plus 16. A single-cycle enable request starts a fixed walk, one step per cycle. First the optional soft reset is released. Next the multiplier code captured with the request is loaded. Last, the power-down control is driven to its running level. The block then waits for the PLL lock flag, with a cycle-count timeout derived from the control-clock frequency and a timeout in microseconds. If lock does not come in time, the enable finishes anyway with a sticky error flag set, and the PLL is left powered.

A single-cycle disable request reverses the walk: the PLL is powered down, and one cycle later the soft reset is reasserted. The power-up polarity and the presence of soft reset are parameters. A powered status output follows the power-down control through the polarity. A busy output covers every sequencing cycle.

A separate combinational helper takes a reference and a target frequency in kHz. It proposes a multiplier code and flags whether the request is legal.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, `pll_pd` sits at the off level (equal to `PU_POL`), `pll_nrst` is 0 when soft reset is present, and `pll_mult`, `busy`, `lock_err` and `pwr_on` are 0.
- R2: An `en_req` accepted in the idle state sets `pll_nrst` to 1 one cycle after the request edge. `pll_mult` takes the code sampled with the request one cycle later. `pll_pd` moves to the on level one cycle after that. `pll_mult` stays stable while the PLL is powered.
- R3: The on level of `pll_pd` is the inverse of `PU_POL`, so with `PU_POL`=1 the PLL runs at `pll_pd`=0 and with `PU_POL`=0 it runs at `pll_pd`=1. `pwr_on` is 1 exactly when `pll_pd` is at the on level.
- R4: `busy` is 1 from the cycle after an accepted request until `pll_lock` is sampled high in the wait phase. It falls on that edge and `lock_err` stays 0.
- R5: If `pll_lock` stays low, the wait phase lasts exactly T = CLK_KHZ*TIMEOUT_US/1000 cycles (at least 1). Then `busy` falls, `lock_err` goes to 1 and the PLL stays powered.
- R6: `lock_err` is sticky through disable and idle. It clears on the edge that accepts the next `en_req`.
- R7: A `dis_req` in any non-idle state drives `pll_pd` to the off level one cycle after the request edge, and sets `pll_nrst` to 0 one cycle later. `busy` is high for those two cycles.
- R8: `en_req` outside the idle state and `dis_req` in the idle state have no effect on any output.
- R9: A `dis_req` during the lock wait aborts it without setting `lock_err`.
- R10: With soft reset absent (`HAS_RESET`=0), `pll_nrst` is held at 1 at all times.
- R11: `fit_ok` is 1 only when `ref_khz` is nonzero and at most 40000, `tgt_khz` lies in 384000..660000 inclusive, and the resulting code is at most 7.
- R12: The code is the integer quotient tgt_khz/ref_khz minus 16, with quotients below 16 clamped to code 0. `fit_code` carries it when `fit_ok` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Single-cycle enable request |
| dis_req | input | 1 | Single-cycle disable request |
| mult_code | input | CODE_W | Multiplier code captured with an enable request |
| pll_lock | input | 1 | Lock flag from the PLL |
| pll_nrst | output | 1 | Soft reset to the PLL, active low |
| pll_pd | output | 1 | Power-down control to the PLL |
| pll_mult | output | CODE_W | Multiplier code to the PLL (factor = code + 16) |
| pwr_on | output | 1 | PLL is powered |
| busy | output | 1 | Sequence in progress |
| lock_err | output | 1 | Sticky lock-timeout flag |
| ref_khz | input | KHZ_W | Helper: reference frequency in kHz |
| tgt_khz | input | KHZ_W | Helper: requested output frequency in kHz |
| fit_code | output | CODE_W | Helper: proposed multiplier code |
| fit_ok | output | 1 | Helper: request is legal |

## Verification
The assertions check the ordering rules on every cycle. Power is never on while soft reset is held. Soft reset only returns after power is already off. The multiplier does not move while the PLL is powered. No wait lasts longer than the timeout bound. An error only rises at the end of a busy, powered phase. The helper's ok flag never accompanies an out-of-band or over-fast request.

Several properties can only be shown by the bench scenarios. These are the exact cycle on which each control moves, the exact wait length for a given lock delay, the error's survival across disable, the ignored requests, and the full arithmetic of code selection over a sweep of reference and target frequencies.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REL,
        ST_LOAD,
        ST_PWR,
        ST_WAIT,
        ST_RUN,
        ST_PDN,
        ST_ARST
    } seq_st_e;

    localparam int BAND_LO_KHZ = 384000;
    localparam int BAND_HI_KHZ = 660000;
    localparam int REF_MAX_KHZ = 40000;
    localparam int MULT_BASE   = 16;

    // Lock-wait length in control-clock cycles, never below one.
    function automatic int timeout_cycles(input int clk_khz, input int tmo_us);
        int c;
        c = (clk_khz * tmo_us) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int CODE_W    = 3,
    parameter bit PU_POL    = 1'b1,
    parameter bit HAS_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic [CODE_W-1:0] code_in,
    input  logic              lock,
    input  logic              tmr_exp,
    output logic              tmr_clr,
    output logic              tmr_run,
    output logic              nrst_o,
    output logic              pd_o,
    output logic [CODE_W-1:0] mult_o,
    output logic              busy_o,
    output logic              err_o
);
    localparam logic PD_OFF   = PU_POL;
    localparam logic PD_ON    = ~PU_POL;
    localparam logic NRST_IDLE = HAS_RESET ? 1'b0 : 1'b1;

    seq_st_e           st;
    logic [CODE_W-1:0] code_q;
    logic              can_stop;

    assign can_stop = (st == ST_REL) || (st == ST_LOAD) || (st == ST_PWR) ||
                      (st == ST_WAIT) || (st == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            nrst_o <= NRST_IDLE;
            pd_o   <= PD_OFF;
            mult_o <= '0;
            code_q <= '0;
            err_o  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (en_req) begin
                        st     <= ST_REL;
                        code_q <= code_in;
                        err_o  <= 1'b0;
                    end
                end
                ST_REL: begin
                    nrst_o <= 1'b1;
                    st     <= ST_LOAD;
                end
                ST_LOAD: begin
                    mult_o <= code_q;
                    st     <= ST_PWR;
                end
                ST_PWR: begin
                    pd_o <= PD_ON;
                    st   <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (lock) begin
                        st <= ST_RUN;
                    end else if (tmr_exp) begin
                        err_o <= 1'b1;
                        st    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    st <= ST_RUN;
                end
                ST_PDN: begin
                    pd_o <= PD_OFF;
                    st   <= ST_ARST;
                end
                ST_ARST: begin
                    nrst_o <= NRST_IDLE;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
            // A stop request overrides whatever step was due.
            if (dis_req && can_stop) begin
                st <= ST_PDN;
            end
        end
    end

    assign busy_o  = (st != ST_IDLE) && (st != ST_RUN);
    assign tmr_clr = (st == ST_PWR);
    assign tmr_run = (st == ST_WAIT);

endmodule

// File: rtl/pll_rate_fit.sv
module pll_rate_fit
    import pll_seq_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int KHZ_W  = 20
) (
    input  logic [KHZ_W-1:0]  ref_khz,
    input  logic [KHZ_W-1:0]  tgt_khz,
    output logic [CODE_W-1:0] code,
    output logic              ok
);
    localparam logic [KHZ_W-1:0] LO_K   = KHZ_W'(BAND_LO_KHZ);
    localparam logic [KHZ_W-1:0] HI_K   = KHZ_W'(BAND_HI_KHZ);
    localparam logic [KHZ_W-1:0] RMAX_K = KHZ_W'(REF_MAX_KHZ);
    localparam logic [KHZ_W-1:0] BASE_K = KHZ_W'(MULT_BASE);
    localparam logic [KHZ_W-1:0] CMAX_K = KHZ_W'((1 << CODE_W) - 1);

    logic [KHZ_W-1:0] quot;
    logic [KHZ_W-1:0] fac;
    logic [KHZ_W-1:0] raw;
    logic             ref_good;
    logic             band_good;

    always_comb begin
        quot      = (ref_khz != '0) ? (tgt_khz / ref_khz) : '0;
        fac       = (quot < BASE_K) ? BASE_K : quot;
        raw       = fac - BASE_K;
        ref_good  = (ref_khz != '0) && (ref_khz <= RMAX_K);
        band_good = (tgt_khz >= LO_K) && (tgt_khz <= HI_K);
        ok        = ref_good && band_good && (raw <= CMAX_K);
        code      = ok ? raw[CODE_W-1:0] : '0;
    end

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
    import pll_seq_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int KHZ_W      = 20,
    parameter int CLK_KHZ    = 100000,
    parameter int TIMEOUT_US = 10000,
    parameter bit PU_POL     = 1'b1,
    parameter bit HAS_RESET  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic [CODE_W-1:0] mult_code,
    input  logic              pll_lock,
    output logic              pll_nrst,
    output logic              pll_pd,
    output logic [CODE_W-1:0] pll_mult,
    output logic              pwr_on,
    output logic              busy,
    output logic              lock_err,
    input  logic [KHZ_W-1:0]  ref_khz,
    input  logic [KHZ_W-1:0]  tgt_khz,
    output logic [CODE_W-1:0] fit_code,
    output logic              fit_ok
);
    localparam int  TO_CYCLES = timeout_cycles(CLK_KHZ, TIMEOUT_US);
    localparam logic PD_ON    = ~PU_POL;

    logic tmr_clr;
    logic tmr_run;
    logic tmr_exp;

    pll_seq_ctrl #(
        .CODE_W   (CODE_W),
        .PU_POL   (PU_POL),
        .HAS_RESET(HAS_RESET)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_req  (en_req),
        .dis_req (dis_req),
        .code_in (mult_code),
        .lock    (pll_lock),
        .tmr_exp (tmr_exp),
        .tmr_clr (tmr_clr),
        .tmr_run (tmr_run),
        .nrst_o  (pll_nrst),
        .pd_o    (pll_pd),
        .mult_o  (pll_mult),
        .busy_o  (busy),
        .err_o   (lock_err)
    );

    pll_lock_timer #(
        .LIMIT(TO_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    pll_rate_fit #(
        .CODE_W(CODE_W),
        .KHZ_W (KHZ_W)
    ) u_fit (
        .ref_khz (ref_khz),
        .tgt_khz (tgt_khz),
        .code    (fit_code),
        .ok      (fit_ok)
    );

    assign pwr_on = (pll_pd == PD_ON);

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
    parameter int CODE_W    = 3,
    parameter int KHZ_W     = 20,
    parameter int LIMIT     = 1000,
    parameter bit HAS_RESET = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              en_req,
    input logic              pll_nrst,
    input logic [CODE_W-1:0] pll_mult,
    input logic              pwr_on,
    input logic              busy,
    input logic              lock_err,
    input logic [KHZ_W-1:0]  ref_khz,
    input logic [KHZ_W-1:0]  tgt_khz,
    input logic [CODE_W-1:0] fit_code,
    input logic              fit_ok
);
    localparam int CW = $clog2(LIMIT + 3);

    logic [CW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || !(busy && pwr_on)) begin
            wcnt <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
        end
    end

    assert_pwr_needs_nrst_R2: assert property (@(posedge clk) disable iff (rst)
        pwr_on |-> pll_nrst);

    assert_mult_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (pwr_on && $past(pwr_on)) |-> $stable(pll_mult));

    assert_rise_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_on) |-> $past(pll_nrst));

    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && pwr_on) |-> (wcnt <= CW'(LIMIT)));

    assert_err_after_wait_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_err) |-> ($past(busy) && pwr_on && !busy));

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(en_req) && !$past(busy) && !$past(pwr_on)) |-> !lock_err);

    assert_nrst_after_off_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_nrst) |-> (!pwr_on && !$past(pwr_on)));

    generate
        if (!HAS_RESET) begin : g_no_rst
            assert_nrst_held_R10: assert property (@(posedge clk) disable iff (rst)
                pll_nrst);
        end
    endgenerate

    assert_fit_legal_R11: assert property (@(posedge clk) disable iff (rst)
        fit_ok |-> ((ref_khz != '0) && (ref_khz <= KHZ_W'(40000)) &&
                    (tgt_khz >= KHZ_W'(384000)) && (tgt_khz <= KHZ_W'(660000))));

    assert_fit_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !fit_ok |-> (fit_code == '0));

endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(
    .CODE_W   (CODE_W),
    .KHZ_W    (KHZ_W),
    .LIMIT    (TO_CYCLES),
    .HAS_RESET(HAS_RESET)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_req   (en_req),
    .pll_nrst (pll_nrst),
    .pll_mult (pll_mult),
    .pwr_on   (pwr_on),
    .busy     (busy),
    .lock_err (lock_err),
    .ref_khz  (ref_khz),
    .tgt_khz  (tgt_khz),
    .fit_code (fit_code),
    .fit_ok   (fit_ok)
);

// File: tb/test_pll_pwr_seq.sv
module test_pll_pwr_seq;
    localparam int CLK_P  = 10;
    localparam int LIMIT  = 40;   // 2000 kHz * 20 us / 1000

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_req = 1'b0;
    logic        dis_req = 1'b0;
    logic [2:0]  mult_code = '0;
    logic        pll_lock = 1'b0;
    logic [19:0] ref_khz = '0;
    logic [19:0] tgt_khz = '0;

    logic        nrst_a, pd_a, pwr_a, busy_a, err_a, ok_a;
    logic [2:0]  mult_a, fcode_a;
    logic        nrst_b, pd_b, pwr_b, busy_b, err_b, ok_b;
    logic [2:0]  mult_b, fcode_b;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    pll_pwr_seq #(.CLK_KHZ(2000), .TIMEOUT_US(20), .PU_POL(1'b1), .HAS_RESET(1'b1)) i_pll_pwr_seq (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .mult_code(mult_code),
        .pll_lock(pll_lock), .pll_nrst(nrst_a), .pll_pd(pd_a), .pll_mult(mult_a),
        .pwr_on(pwr_a), .busy(busy_a), .lock_err(err_a), .ref_khz(ref_khz),
        .tgt_khz(tgt_khz), .fit_code(fcode_a), .fit_ok(ok_a));

    pll_pwr_seq #(.CLK_KHZ(2000), .TIMEOUT_US(20), .PU_POL(1'b0), .HAS_RESET(1'b0)) i_pll_pwr_seq_b (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .mult_code(mult_code),
        .pll_lock(pll_lock), .pll_nrst(nrst_b), .pll_pd(pd_b), .pll_mult(mult_b),
        .pwr_on(pwr_b), .busy(busy_b), .lock_err(err_b), .ref_khz(ref_khz),
        .tgt_khz(tgt_khz), .fit_code(fcode_b), .fit_ok(ok_b));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Enable with lock arriving lock_after cycles into the wait; negative = never.
    task automatic enable_seq(input logic [2:0] c, input int lock_after);
        en_req = 1'b1; mult_code = c;
        tick();
        en_req = 1'b0; mult_code = ~c;
        chk("R2 busy after request", busy_a, 1);
        chk("R6 err cleared by request", err_a, 0);
        chk("R2 nrst still low", nrst_a, 0);
        tick();
        chk("R2 nrst released", nrst_a, 1);
        chk("R2 not yet powered", pwr_a, 0);
        tick();
        chk("R2 mult loaded", mult_a, c);
        chk("R2 mult loaded b", mult_b, c);
        chk("R2 power after load", pwr_a, 0);
        tick();
        chk("R3 pd on level pol1", pd_a, 0);
        chk("R3 pd on level pol0", pd_b, 1);
        chk("R3 pwr_on a", pwr_a, 1);
        chk("R3 pwr_on b", pwr_b, 1);
        chk("R10 nrst held b", nrst_b, 1);
        if (lock_after >= 0) begin
            for (int k = 0; k < lock_after; k++) begin
                tick();
                chk("R4 busy while unlocked", busy_a, 1);
            end
            pll_lock = 1'b1;
            tick();
            chk("R4 busy falls on lock", busy_a, 0);
            chk("R4 no error on lock", err_a, 0);
            chk("R4 busy falls b", busy_b, 0);
        end else begin
            for (int k = 1; k < LIMIT; k++) begin
                tick();
                if (busy_a != 1'b1 || err_a != 1'b0)
                    chk("R5 wait before timeout", {busy_a, err_a}, 2);
            end
            chk("R5 still waiting at T-1", busy_a, 1);
            tick();
            chk("R5 busy drops at timeout", busy_a, 0);
            chk("R5 err set at timeout", err_a, 1);
            chk("R5 err set b", err_b, 1);
            chk("R5 still powered", pwr_a, 1);
        end
    endtask

    task automatic disable_seq();
        dis_req = 1'b1;
        tick();
        dis_req = 1'b0;
        chk("R7 busy during stop", busy_a, 1);
        tick();
        chk("R7 pd off level pol1", pd_a, 1);
        chk("R7 pd off level pol0", pd_b, 0);
        chk("R7 nrst still high", nrst_a, 1);
        chk("R7 busy second cycle", busy_a, 1);
        pll_lock = 1'b0;
        tick();
        chk("R7 nrst asserted", nrst_a, 0);
        chk("R7 busy done", busy_a, 0);
        chk("R10 nrst held b", nrst_b, 1);
    endtask

    function automatic int exp_ok(input int r, input int t);
        int n;
        if (r == 0 || r > 40000 || t < 384000 || t > 660000) return 0;
        n = t / r;
        if (n < 16) n = 16;
        return (n - 16 <= 7) ? 1 : 0;
    endfunction

    function automatic int exp_code(input int r, input int t);
        int n;
        if (exp_ok(r, t) == 0) return 0;
        n = t / r;
        if (n < 16) n = 16;
        return n - 16;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int refs [10] = '{0, 10000, 20000, 24000, 25000, 27000, 30000, 40000, 40001, 50000};
        int edges [4] = '{383999, 384000, 660000, 660001};
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 pd off pol1", pd_a, 1);
        chk("R1 pd off pol0", pd_b, 0);
        chk("R1 nrst low", nrst_a, 0);
        chk("R1 mult zero", mult_a, 0);
        chk("R1 busy low", busy_a, 0);
        chk("R1 err low", err_a, 0);
        chk("R1 pwr_on low", pwr_a, 0);
        chk("R10 nrst held after reset", nrst_b, 1);

        // R8 stop request while idle
        dis_req = 1'b1; tick(); dis_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 idle stop ignored busy", busy_a, 0);
            chk("R8 idle stop ignored pd", pd_a, 1);
            tick();
        end

        // R2 R3 R4 basic enable with immediate lock
        enable_seq(3'd5, 0);
        // R8 enable while running
        en_req = 1'b1; mult_code = 3'd2; tick(); en_req = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk("R8 run enable ignored busy", busy_a, 0);
            chk("R8 run enable ignored mult", mult_a, 5);
            chk("R8 run enable ignored pwr", pwr_a, 1);
            tick();
        end
        disable_seq();

        // R4 delayed lock
        enable_seq(3'd3, 7);
        disable_seq();

        // R2 sweep over all codes
        for (int c = 0; c < 8; c++) begin
            enable_seq(3'(c), c % 3);
            disable_seq();
        end

        // R5 timeout then R6 stickiness
        enable_seq(3'd7, -1);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R6 err sticky in run", err_a, 1);
        end
        disable_seq();
        tick();
        chk("R6 err sticky in idle", err_a, 1);
        chk("R6 err sticky idle b", err_b, 1);

        // R9 abort during wait (first steps also check R6 clear)
        en_req = 1'b1; mult_code = 3'd1; tick(); en_req = 1'b0;
        chk("R6 err cleared", err_a, 0);
        repeat (5) tick();
        chk("R9 in wait", busy_a, 1);
        disable_seq();
        chk("R9 no err after abort", err_a, 0);
        repeat (LIMIT + 5) tick();
        chk("R9 still no err", err_a, 0);
        chk("R9 stays idle", busy_a, 0);
        chk("R9 stays off", pwr_a, 0);

        // R11 R12 helper sweep
        for (int i = 0; i < 10; i++) begin
            for (int t = 380000; t <= 665000; t += 500) begin
                ref_khz = 20'(refs[i]); tgt_khz = 20'(t);
                #1;
                if (ok_a != exp_ok(refs[i], t) || fcode_a != exp_code(refs[i], t)) begin
                    chk("R11 fit ok", ok_a, exp_ok(refs[i], t));
                    chk("R12 fit code", fcode_a, exp_code(refs[i], t));
                end else begin
                    total += 2;
                end
            end
            for (int e = 0; e < 4; e++) begin
                ref_khz = 20'(refs[i]); tgt_khz = 20'(edges[e]);
                #1;
                chk("R11 band edge ok", ok_a, exp_ok(refs[i], edges[e]));
                chk("R12 band edge code", fcode_a, exp_code(refs[i], edges[e]));
                chk("R12 band edge code b", fcode_b, exp_code(refs[i], edges[e]));
            end
        end
        // R12 clamp: 384000/30000 = 12 -> code 0, legal
        ref_khz = 20'd30000; tgt_khz = 20'd384000; #1;
        chk("R12 clamp ok", ok_a, 1);
        chk("R12 clamp code", fcode_a, 0);
        // R11 code overflow: 660000/24000 = 27 -> code 11 rejected
        ref_khz = 20'd24000; tgt_khz = 20'd660000; #1;
        chk("R11 overflow rejected", ok_a, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule